// File: doc/BRIEF.md
# Scaled Integer Arithmetic Unit

This block is the integer arithmetic slice of an execution pipeline. It takes two 64-bit operands and a 7-bit function code. It computes one of several results: a 32-bit (narrow) or 64-bit (wide) sum or difference, a sum or difference where the first operand is first multiplied by 4 or 8, a signed or unsigned scalar compare, or a per-byte unsigned compare mask. The combinational datapath feeds a single output register stage.

Four of the add and subtract codes are trapping variants. For these, the block reports signed overflow on a flag. It only raises the flag and leaves handling of the exception to the surrounding pipeline. Codes the block does not recognise are reported on a separate output, and their result is forced to zero. Choosing between a register operand and a literal is the caller's job.

Top module: `sia_unit`

## Requirements
- R1: Narrow add (0x00) and narrow subtract (0x09) use only bits 31:0 of both operands. Bit 31 of the 32-bit result is copied into bits 63:32.
- R2: Wide add (0x20) and wide subtract (0x29) produce the 64-bit sum or difference modulo 2^64.
- R3: The scaled codes shift the first operand left before the add or subtract. A shift of 2 applies to 0x02, 0x22, 0x0b and 0x2b. A shift of 3 applies to 0x12, 0x32, 0x1b and 0x3b. The codes 0x02, 0x12, 0x0b and 0x1b are narrow: the shifted value is truncated to 32 bits before the result is sign-extended.
- R4: The overflow flag can only be set for the trapping codes 0x40 (narrow add), 0x60 (wide add), 0x49 (narrow subtract) and 0x69 (wide subtract). For every other code it is 0, including scaled results that wrap.
- R5: A trapping add flags overflow when the two operand sign bits are equal and the result sign differs from the first operand's sign. The sign bit is bit 31 for narrow codes and bit 63 for wide codes. The result is still delivered.
- R6: A trapping subtract flags overflow when the two operand sign bits differ and the result sign differs from the first operand's sign.
- R7: The scalar compares return 1 or 0 in the 64-bit result: 0x2d equal, 0x6d signed less-or-equal, 0x4d signed less-than, 0x3d unsigned less-or-equal, 0x1d unsigned less-than.
- R8: Code 0x0f sets result bit i (i = 0..7) when byte i of the first operand is greater than or equal to byte i of the second, both taken as unsigned. Bits 63:8 are zero.
- R9: Any other code sets `illegal`, gives a zero result and keeps the overflow flag clear. Listed codes clear `illegal`.
- R10: When `in_vld` is high at a clock edge, `result`, `ovf` and `illegal` take that cycle's values at that edge and `out_vld` is high for the following cycle. Without `in_vld`, `out_vld` is low and the other outputs hold their values.
- R11: While reset is asserted, `out_vld`, `result`, `ovf` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Operands and function code are valid this cycle |
| func | input | 7 | Function code |
| opa | input | 64 | First operand (the one that is scaled) |
| opb | input | 64 | Second operand |
| out_vld | output | 1 | Registered outputs carry a new result |
| result | output | 64 | Registered result |
| ovf | output | 1 | Registered signed-overflow flag for the trapping codes |
| illegal | output | 1 | Registered unrecognised-function flag |

## Verification
The hardest case to reach from the ports is where the overflow rule and the width selection interact. A narrow trapping operation must judge its sign at bit 31 even when bit 63 says something different. A scaled operation must wrap without raising the flag. The stimulus table therefore uses operands whose bit 31 and bit 63 disagree, operand pairs that sit exactly on the signed boundary for both add and subtract, and scaled operands whose shifted bits fall off the 32-bit or 64-bit edge. The table is applied on back-to-back strobes, so each registered result is also checked against the operation issued in the cycle before it.

// File: rtl/sia_pkg.sv
package sia_pkg;

  localparam int FUNC_W = 7;

  // function codes
  localparam logic [FUNC_W-1:0] F_ADDN    = 7'h00;
  localparam logic [FUNC_W-1:0] F_ADDN_T  = 7'h40;
  localparam logic [FUNC_W-1:0] F_ADDN_X4 = 7'h02;
  localparam logic [FUNC_W-1:0] F_ADDN_X8 = 7'h12;
  localparam logic [FUNC_W-1:0] F_ADDW    = 7'h20;
  localparam logic [FUNC_W-1:0] F_ADDW_T  = 7'h60;
  localparam logic [FUNC_W-1:0] F_ADDW_X4 = 7'h22;
  localparam logic [FUNC_W-1:0] F_ADDW_X8 = 7'h32;
  localparam logic [FUNC_W-1:0] F_SUBN    = 7'h09;
  localparam logic [FUNC_W-1:0] F_SUBN_T  = 7'h49;
  localparam logic [FUNC_W-1:0] F_SUBN_X4 = 7'h0b;
  localparam logic [FUNC_W-1:0] F_SUBN_X8 = 7'h1b;
  localparam logic [FUNC_W-1:0] F_SUBW    = 7'h29;
  localparam logic [FUNC_W-1:0] F_SUBW_T  = 7'h69;
  localparam logic [FUNC_W-1:0] F_SUBW_X4 = 7'h2b;
  localparam logic [FUNC_W-1:0] F_SUBW_X8 = 7'h3b;
  localparam logic [FUNC_W-1:0] F_CEQ     = 7'h2d;
  localparam logic [FUNC_W-1:0] F_CSLE    = 7'h6d;
  localparam logic [FUNC_W-1:0] F_CSLT    = 7'h4d;
  localparam logic [FUNC_W-1:0] F_CULE    = 7'h3d;
  localparam logic [FUNC_W-1:0] F_CULT    = 7'h1d;
  localparam logic [FUNC_W-1:0] F_CBYTE   = 7'h0f;

  typedef enum logic [2:0] {
    CMP_NONE = 3'd0,
    CMP_EQ   = 3'd1,
    CMP_SLE  = 3'd2,
    CMP_SLT  = 3'd3,
    CMP_ULE  = 3'd4,
    CMP_ULT  = 3'd5,
    CMP_BYTE = 3'd6
  } cmp_kind_e;

  typedef struct packed {
    logic      legal;
    logic      use_cmp;
    logic      sub;
    logic      narrow;
    logic [1:0] shamt;
    logic      trap;
    cmp_kind_e cmp;
  } op_ctl_t;

endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output op_ctl_t           ctl
);

  always_comb begin
    ctl         = '0;
    ctl.cmp     = CMP_NONE;
    ctl.legal   = 1'b1;
    case (func)
      F_ADDN:    begin ctl.narrow = 1'b1; end
      F_ADDN_T:  begin ctl.narrow = 1'b1; ctl.trap = 1'b1; end
      F_ADDN_X4: begin ctl.narrow = 1'b1; ctl.shamt = 2'd2; end
      F_ADDN_X8: begin ctl.narrow = 1'b1; ctl.shamt = 2'd3; end
      F_ADDW:    begin end
      F_ADDW_T:  begin ctl.trap = 1'b1; end
      F_ADDW_X4: begin ctl.shamt = 2'd2; end
      F_ADDW_X8: begin ctl.shamt = 2'd3; end
      F_SUBN:    begin ctl.sub = 1'b1; ctl.narrow = 1'b1; end
      F_SUBN_T:  begin ctl.sub = 1'b1; ctl.narrow = 1'b1; ctl.trap = 1'b1; end
      F_SUBN_X4: begin ctl.sub = 1'b1; ctl.narrow = 1'b1; ctl.shamt = 2'd2; end
      F_SUBN_X8: begin ctl.sub = 1'b1; ctl.narrow = 1'b1; ctl.shamt = 2'd3; end
      F_SUBW:    begin ctl.sub = 1'b1; end
      F_SUBW_T:  begin ctl.sub = 1'b1; ctl.trap = 1'b1; end
      F_SUBW_X4: begin ctl.sub = 1'b1; ctl.shamt = 2'd2; end
      F_SUBW_X8: begin ctl.sub = 1'b1; ctl.shamt = 2'd3; end
      F_CEQ:     begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_EQ;   end
      F_CSLE:    begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_SLE;  end
      F_CSLT:    begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_SLT;  end
      F_CULE:    begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_ULE;  end
      F_CULT:    begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_ULT;  end
      F_CBYTE:   begin ctl.use_cmp = 1'b1; ctl.cmp = CMP_BYTE; end
      default:   begin ctl.legal = 1'b0; end
    endcase
  end

endmodule

// File: rtl/sia_addsub.sv
module sia_addsub #(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          sub,
  input  logic          narrow,
  input  logic [1:0]    shamt,
  input  logic          trap,
  output logic [DW-1:0] res,
  output logic          ovf
);

  localparam int EXT_W = DW - NW;

  logic [DW-1:0] a_sc;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] raw;
  logic          sign_a, sign_b, sign_r;

  // one carry-propagate adder serves both add and subtract
  always_comb begin
    a_sc  = opa << shamt;
    b_eff = sub ? ~opb : opb;
    raw   = a_sc + b_eff + {{(DW-1){1'b0}}, sub};
  end

  always_comb begin
    if (narrow) begin
      res    = {{EXT_W{raw[NW-1]}}, raw[NW-1:0]};
      sign_a = opa[NW-1];
      sign_b = opb[NW-1];
      sign_r = raw[NW-1];
    end else begin
      res    = raw;
      sign_a = opa[DW-1];
      sign_b = opb[DW-1];
      sign_r = raw[DW-1];
    end
  end

  always_comb begin
    if (sub)
      ovf = trap & (sign_a != sign_b) & (sign_r != sign_a);
    else
      ovf = trap & (sign_a == sign_b) & (sign_r != sign_a);
  end

endmodule

// File: rtl/sia_cmp.sv
module sia_cmp
  import sia_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  cmp_kind_e     kind,
  output logic [DW-1:0] res
);

  localparam int NBYTE = DW / 8;

  logic [NBYTE-1:0] byte_ge;
  logic             eq, slt, ult;

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign byte_ge[g] = (opa[8*g +: 8] >= opb[8*g +: 8]);
  end

  always_comb begin
    eq  = (opa == opb);
    slt = ($signed(opa) < $signed(opb));
    ult = (opa < opb);
  end

  always_comb begin
    res = '0;
    case (kind)
      CMP_EQ:   res[0] = eq;
      CMP_SLE:  res[0] = slt | eq;
      CMP_SLT:  res[0] = slt;
      CMP_ULE:  res[0] = ult | eq;
      CMP_ULT:  res[0] = ult;
      CMP_BYTE: res[NBYTE-1:0] = byte_ge;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/sia_unit.sv
module sia_unit
  import sia_pkg::*;
#(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [FUNC_W-1:0] func,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  output logic              out_vld,
  output logic [DW-1:0]     result,
  output logic              ovf,
  output logic              illegal
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  op_ctl_t       ctl;
  logic [DW-1:0] arith_res;
  logic          arith_ovf;
  logic [DW-1:0] cmp_res;

  sia_decode u_dec (
    .func (func),
    .ctl  (ctl)
  );

  sia_addsub #(.DW(DW), .NW(NW)) u_arith (
    .opa    (opa),
    .opb    (opb),
    .sub    (ctl.sub),
    .narrow (ctl.narrow),
    .shamt  (ctl.shamt),
    .trap   (ctl.trap),
    .res    (arith_res),
    .ovf    (arith_ovf)
  );

  sia_cmp #(.DW(DW)) u_cmp (
    .opa  (opa),
    .opb  (opb),
    .kind (ctl.cmp),
    .res  (cmp_res)
  );

  // next-state
  logic [DW-1:0] result_d;
  logic          ovf_d;
  logic          illegal_d;

  always_comb begin
    if (!ctl.legal) begin
      result_d = '0;
      ovf_d    = 1'b0;
    end else if (ctl.use_cmp) begin
      result_d = cmp_res;
      ovf_d    = 1'b0;
    end else begin
      result_d = arith_res;
      ovf_d    = arith_ovf;
    end
    illegal_d = ~ctl.legal;
  end

  // registers, enabled by the input strobe
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result  <= '0;
      ovf     <= 1'b0;
      illegal <= 1'b0;
    end else if (in_vld) begin
      result  <= result_d;
      ovf     <= ovf_d;
      illegal <= illegal_d;
    end
  end

  // checks
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_vld |=> out_vld); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> !out_vld); // R10
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> $stable(result) && $stable(ovf) && $stable(illegal)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && !ctl.trap) |=> !ovf); // R4
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_vld && illegal) |-> (result == '0) && !ovf); // R9
  AST_BYTE_MASK_NARROW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && ctl.cmp == CMP_BYTE) |=> (result[DW-1:8] == '0)); // R8

endmodule

// File: tb/sim_sia_unit.sv
`timescale 1ns/1ps
module sim_sia_unit;

  localparam int DW = 64;
  localparam int NV = 30;
  localparam realtime TCK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [6:0]    func = '0;
  logic [DW-1:0] opa = '0;
  logic [DW-1:0] opb = '0;
  logic          out_vld;
  logic [DW-1:0] result;
  logic          ovf;
  logic          illegal;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  sia_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .func(func),
    .opa(opa), .opb(opb), .out_vld(out_vld), .result(result),
    .ovf(ovf), .illegal(illegal)
  );

  localparam logic [6:0] VF [NV] = '{
    7'h00, 7'h40, 7'h40, 7'h20, 7'h60, 7'h60, 7'h09, 7'h49, 7'h69, 7'h69,
    7'h29, 7'h02, 7'h12, 7'h22, 7'h32, 7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h2d,
    7'h2d, 7'h6d, 7'h3d, 7'h4d, 7'h1d, 7'h4d, 7'h0f, 7'h0f, 7'h7f, 7'h01};
  localparam logic [63:0] VA [NV] = '{
    64'h0000_0001_7FFF_FFFF, 64'h0000_0001_7FFF_FFFF, 64'd5,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'd3, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'd5,
    64'd10, 64'd3, 64'd3, 64'h4000_0000_0000_0000, 64'd2,
    64'd1, 64'h0000_0000_2000_0000, 64'd10, 64'd1, 64'd7,
    64'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd0,
    64'hFFFF_FFFF_FFFF_FFFE, 64'h0102_0304_0506_0708, 64'd0, 64'd1, 64'd1};
  localparam logic [63:0] VB [NV] = '{
    64'd1, 64'd1, 64'd3,
    64'd1, 64'd1, 64'h8000_0000_0000_0000,
    64'd5, 64'd1, 64'd1, 64'd5,
    64'd3, 64'd1, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
    64'd5, 64'd0, 64'd1, 64'd8, 64'd7,
    64'd8, 64'd0, 64'd0, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0202_0202_0202_0202, 64'd0, 64'd1, 64'd1};
  localparam logic [63:0] VR [NV] = '{
    64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000, 64'd8,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0,
    64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0,
    64'd7, 64'd13, 64'd25, 64'd0, 64'd15,
    64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd39, 64'd0, 64'd1,
    64'd0, 64'd1, 64'd0, 64'd0, 64'd1,
    64'd1, 64'h7F, 64'hFF, 64'd0, 64'd0};
  localparam logic VO [NV] = '{
    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic VI [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam string VT [NV] = '{
    "R1", "R5", "R4", "R2", "R5", "R5", "R1", "R6", "R6", "R6",
    "R2", "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R7",
    "R7", "R7", "R7", "R7", "R7", "R7", "R8", "R8", "R9", "R9"};

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic check_vec(input int k);
    check(VT[k], $sformatf("vec%0d result", k), result, VR[k]);
    check("R4", $sformatf("vec%0d ovf", k), {63'd0, ovf}, {63'd0, VO[k]});
    check("R9", $sformatf("vec%0d illegal", k), {63'd0, illegal}, {63'd0, VI[k]});
    check("R10", $sformatf("vec%0d out_vld", k), {63'd0, out_vld}, 64'd1);
  endtask

  initial begin
    #(TCK * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset state
    #(TCK * 3);
    check("R11", "reset out_vld", {63'd0, out_vld}, 64'd0);
    check("R11", "reset result", result, 64'd0);
    check("R11", "reset ovf", {63'd0, ovf}, 64'd0);
    check("R11", "reset illegal", {63'd0, illegal}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table, back-to-back strobes
    for (int i = 0; i < NV; i++) begin
      func = VF[i]; opa = VA[i]; opb = VB[i]; in_vld = 1'b1;
      @(negedge clk);
      check_vec(i);
    end
    in_vld = 1'b0;

    // R10: hold without strobe
    func = 7'h20; opa = 64'd100; opb = 64'd23; in_vld = 1'b1;
    @(negedge clk);
    check("R2", "hold setup result", result, 64'd123);
    in_vld = 1'b0; func = 7'h60; opa = 64'h7FFF_FFFF_FFFF_FFFF; opb = 64'd1;
    @(negedge clk);
    check("R10", "idle out_vld", {63'd0, out_vld}, 64'd0);
    @(negedge clk);
    check("R10", "held result", result, 64'd123);
    check("R10", "held ovf", {63'd0, ovf}, 64'd0);

    // R11: asynchronous reset mid-run
    func = 7'h40; opa = 64'h7FFF_FFFF; opb = 64'd1; in_vld = 1'b1;
    @(negedge clk);
    check("R5", "pre-reset ovf", {63'd0, ovf}, 64'd1);
    #(TCK / 4);
    rst_n = 1'b0;
    #1;
    check("R11", "async reset result", result, 64'd0);
    check("R11", "async reset ovf", {63'd0, ovf}, 64'd0);
    check("R11", "async reset out_vld", {63'd0, out_vld}, 64'd0);
    in_vld = 1'b0;
    finish_run();
  end

endmodule